// File: doc/BRIEF.md
# Inband Loopback Code Qualifier

This block decides when a line has been sending an inband loopback request long enough to act on. An external pattern matcher looks at each received bit. For every bit it reports whether the bit fits the loopback-up code and whether it fits the loopback-down code. The block runs two independent qualification channels, one for each code. Each channel turns its status bit on only after its code has persisted for a programmable number of millisecond ticks. It then keeps that status on while the residual mismatch rate stays within a tolerance.

A mode input selects between a short persistence time, used when loopback is only reported, and a long one, used when loopback is switched automatically. A rising edge on the up-code status turns the remote loopback control on. A rising edge on the down-code status turns it off. When both status bits rise in the same cycle, turning loopback off takes priority. Time is measured by counting a 1 ms tick input, and error tolerance is judged over fixed windows of received bits.

Top module: `ilb_qualifier_top`

## Requirements
- R1: With `autoMode` = 0, a channel's status goes to 1 on the clock edge that consumes its TICKS_SHORT-th `msTick`, counted while the code is qualifying. The status is therefore visible one cycle after that tick is presented. It stays 0 after TICKS_SHORT-1 ticks.
- R2: With `autoMode` = 1, the same rule applies with TICKS_LONG ticks in place of TICKS_SHORT.
- R3: While a channel is qualifying, once ERR_LIMIT mismatching bits (`bitValid` = 1, match = 0) have accumulated in the current window, its tick count, bit count and error count all restart from zero.
- R4: While a status is 1, up to ERR_LIMIT mismatches within one window of WINDOW_BITS valid bits leave it at 1. The error count restarts at every window boundary. Windows are counted from the edge on which the status was set.
- R5: A status that is 1 returns to 0 on the edge that consumes the (ERR_LIMIT+1)-th mismatch of a window. The channel then restarts qualification. `remoteLoopback` does not change because of this.
- R6: One cycle after the up-code status (`actStatus`) rises, `remoteLoopback` becomes 1.
- R7: One cycle after the down-code status (`deaStatus`) rises, `remoteLoopback` becomes 0.
- R8: If both status bits rise in the same cycle, `remoteLoopback` is 0 one cycle later.
- R9: While `rstN` is 0, `actStatus`, `deaStatus` and `remoteLoopback` are all 0.
- R10: The two channels are independent. The down-code channel qualifies, tolerates errors and clears by the same rules, driven only by `deaMatch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| autoMode | input | 1 | 0 selects TICKS_SHORT persistence, 1 selects TICKS_LONG |
| bitValid | input | 1 | One received bit is being reported this cycle |
| actMatch | input | 1 | The reported bit fits the up code |
| deaMatch | input | 1 | The reported bit fits the down code |
| msTick | input | 1 | One-cycle pulse every millisecond |
| actStatus | output | 1 | Up code qualified |
| deaStatus | output | 1 | Down code qualified |
| remoteLoopback | output | 1 | Remote loopback enable |

## Verification
A corrupted tick count shows up as a status edge that arrives early or late, and the timing is visible at the port to the exact cycle. A stuck window or error count appears within one window of bits. It shows as a status that either drops despite tolerable errors or survives one mismatch too many. A wrong loopback register is exposed one cycle after the next status rising edge. The simultaneous-rise case is what distinguishes a correct priority from a reversed one.

// File: rtl/ilb_pkg.sv
package ilb_pkg;

  localparam int NUM_CODES = 2;
  localparam int CODE_ACT  = 0;
  localparam int CODE_DEA  = 1;

  typedef enum logic {
    ST_QUAL = 1'b0,
    ST_HELD = 1'b1
  } qualState_t;

  // control -> datapath
  typedef struct packed {
    logic clrAll;
    logic runPersist;
  } ctrlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic qualTrip;
    logic heldTrip;
    logic persistHit;
  } dpFlag_t;

endpackage

// File: rtl/ilb_datapath.sv
module ilb_datapath
  import ilb_pkg::*;
#(
  parameter int TICKS_LONG  = 5100,
  parameter int WINDOW_BITS = 1000,
  parameter int ERR_LIMIT   = 10,
  localparam int CNT_W = $clog2(TICKS_LONG + 1),
  localparam int BIT_W = $clog2(WINDOW_BITS),
  localparam int ERR_W = $clog2(ERR_LIMIT + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitValid,
  input  logic             match,
  input  logic             msTick,
  input  logic [CNT_W-1:0] thr,
  input  ctrlStrobe_t      strobe,
  output dpFlag_t          flags
);

  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(TICKS_LONG);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WINDOW_BITS - 1);
  localparam logic [ERR_W-1:0] ERR_LIM  = ERR_W'(ERR_LIMIT);

  logic [CNT_W-1:0] persistCnt;
  logic [BIT_W-1:0] bitCnt;
  logic [ERR_W-1:0] errCnt;
  logic             mismatch;
  logic             windowLast;
  logic [ERR_W-1:0] errNext;

  assign mismatch   = bitValid && !match;
  assign windowLast = bitValid && (bitCnt == BIT_LAST);
  assign errNext    = errCnt + ERR_W'(mismatch);

  always_comb begin
    flags.qualTrip   = mismatch && (errNext >= ERR_LIM);
    flags.heldTrip   = mismatch && (errNext > ERR_LIM);
    flags.persistHit = strobe.runPersist && msTick && ((persistCnt + CNT_W'(1)) >= thr);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      persistCnt <= '0;
      bitCnt     <= '0;
      errCnt     <= '0;
    end else if (strobe.clrAll) begin
      persistCnt <= '0;
      bitCnt     <= '0;
      errCnt     <= '0;
    end else begin
      if (bitValid) begin
        bitCnt <= windowLast ? '0 : bitCnt + BIT_W'(1);
        errCnt <= windowLast ? '0 : errNext;
      end
      if (strobe.runPersist && msTick && (persistCnt != CNT_MAX))
        persistCnt <= persistCnt + CNT_W'(1);
    end
  end

  // the control clears the counters before the error count can pass the limit
  p_err_cap_r5: assert property (@(posedge clk) disable iff (!rstN)
    errCnt <= ERR_LIM);

  p_window_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= BIT_LAST);

  p_bit_advance_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!bitValid && !strobe.clrAll) |=> $stable(bitCnt));

endmodule

// File: rtl/ilb_control.sv
module ilb_control
  import ilb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpFlag_t     flags,
  output ctrlStrobe_t strobe,
  output logic        status
);

  qualState_t state, stateNext;

  always_comb begin
    stateNext         = state;
    strobe.runPersist = (state == ST_QUAL);
    strobe.clrAll     = 1'b0;
    unique case (state)
      ST_QUAL: begin
        if (flags.qualTrip) begin
          strobe.clrAll = 1'b1;
        end else if (flags.persistHit) begin
          strobe.clrAll = 1'b1;
          stateNext     = ST_HELD;
        end
      end
      ST_HELD: begin
        if (flags.heldTrip) begin
          strobe.clrAll = 1'b1;
          stateNext     = ST_QUAL;
        end
      end
      default: stateNext = ST_QUAL;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_QUAL;
    else       state <= stateNext;
  end

  assign status = (state == ST_HELD);

  // a held status only leaves on an error trip reported by the datapath
  p_leave_on_trip_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HELD && !flags.heldTrip) |=> (state == ST_HELD));

  // qualification only completes on a persistence hit
  p_enter_on_hit_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_QUAL && !flags.persistHit) |=> (state == ST_QUAL));

endmodule

// File: rtl/ilb_qualifier_top.sv
module ilb_qualifier_top
  import ilb_pkg::*;
#(
  parameter int TICKS_SHORT = 40,
  parameter int TICKS_LONG  = 5100,
  parameter int WINDOW_BITS = 1000,
  parameter int ERR_LIMIT   = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic autoMode,
  input  logic bitValid,
  input  logic actMatch,
  input  logic deaMatch,
  input  logic msTick,
  output logic actStatus,
  output logic deaStatus,
  output logic remoteLoopback
);

  localparam int CNT_W = $clog2(TICKS_LONG + 1);

  logic [CNT_W-1:0]     thr;
  logic [NUM_CODES-1:0] matchVec;
  logic [NUM_CODES-1:0] statusVec;
  logic [NUM_CODES-1:0] statusQ;
  logic                 actRise;
  logic                 deaRise;

  assign thr = autoMode ? CNT_W'(TICKS_LONG) : CNT_W'(TICKS_SHORT);

  always_comb begin
    matchVec           = '0;
    matchVec[CODE_ACT] = actMatch;
    matchVec[CODE_DEA] = deaMatch;
  end

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_chan
    ctrlStrobe_t strobe;
    dpFlag_t     flags;

    ilb_datapath #(
      .TICKS_LONG (TICKS_LONG),
      .WINDOW_BITS(WINDOW_BITS),
      .ERR_LIMIT  (ERR_LIMIT)
    ) u_dp (
      .clk     (clk),
      .rstN    (rstN),
      .bitValid(bitValid),
      .match   (matchVec[g]),
      .msTick  (msTick),
      .thr     (thr),
      .strobe  (strobe),
      .flags   (flags)
    );

    ilb_control u_ctl (
      .clk   (clk),
      .rstN  (rstN),
      .flags (flags),
      .strobe(strobe),
      .status(statusVec[g])
    );
  end

  assign actStatus = statusVec[CODE_ACT];
  assign deaStatus = statusVec[CODE_DEA];

  assign actRise = statusVec[CODE_ACT] && !statusQ[CODE_ACT];
  assign deaRise = statusVec[CODE_DEA] && !statusQ[CODE_DEA];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ        <= '0;
      remoteLoopback <= 1'b0;
    end else begin
      statusQ <= statusVec;
      if (deaRise)      remoteLoopback <= 1'b0;
      else if (actRise) remoteLoopback <= 1'b1;
    end
  end

  p_set_on_tick_r1: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(actStatus) || $rose(deaStatus)) |-> $past(msTick));

  p_clear_on_miss_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(actStatus) |-> $past(bitValid && !actMatch));

  p_clear_on_miss_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(deaStatus) |-> $past(bitValid && !deaMatch));

  p_lb_on_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(actStatus) && !$rose(deaStatus)) |=> remoteLoopback);

  p_lb_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(deaStatus) |=> !remoteLoopback);

  p_lb_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!$rose(actStatus) && !$rose(deaStatus)) |=> $stable(remoteLoopback));

endmodule

// File: tb/tb_ilb_qualifier_top.sv
module tb_ilb_qualifier_top;

  localparam int TS = 6;
  localparam int TL = 15;
  localparam int WB = 8;
  localparam int EL = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic autoMode = 1'b0, bitValid = 1'b0, actMatch = 1'b0, deaMatch = 1'b0, msTick = 1'b0;
  logic actStatus, deaStatus, remoteLoopback;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  always #2.5 clk = ~clk;

  ilb_qualifier_top #(
    .TICKS_SHORT(TS), .TICKS_LONG(TL), .WINDOW_BITS(WB), .ERR_LIMIT(EL)
  ) dut (
    .clk(clk), .rstN(rstN), .autoMode(autoMode), .bitValid(bitValid),
    .actMatch(actMatch), .deaMatch(deaMatch), .msTick(msTick),
    .actStatus(actStatus), .deaStatus(deaStatus), .remoteLoopback(remoteLoopback)
  );

  // entry: {count[7:0], bv, am, dm, tick, mode, expAct, expDea, expLb, req[3:0]}
  localparam int NVEC = 10;
  localparam logic [19:0] VEC [NVEC] = '{
    {8'd5, 5'b11010, 3'b000, 4'd1},   // R1: five ticks, not yet
    {8'd1, 5'b11010, 3'b100, 4'd1},   // R1: sixth tick sets up status
    {8'd1, 5'b11010, 3'b101, 4'd6},   // R6: loopback follows one cycle later
    {8'd2, 5'b10000, 3'b101, 4'd4},   // R4: two misses tolerated
    {8'd5, 5'b11000, 3'b101, 4'd4},   // R4: window boundary resets count
    {8'd2, 5'b10000, 3'b101, 4'd4},   // R4: two misses in new window
    {8'd1, 5'b10000, 3'b001, 4'd5},   // R5: third miss clears, loopback kept
    {8'd5, 5'b10110, 3'b001, 4'd10},  // R10: down code five ticks
    {8'd1, 5'b10110, 3'b011, 4'd10},  // R10: down status sets
    {8'd1, 5'b10110, 3'b010, 4'd7}    // R7: loopback off
  };

  task automatic check(input string req, input logic act, input logic exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkAll(input string req, input logic eA, input logic eD, input logic eL);
    check({req, " actStatus"}, actStatus, eA);
    check({req, " deaStatus"}, deaStatus, eD);
    check({req, " remoteLoopback"}, remoteLoopback, eL);
  endtask

  task automatic step(input logic bv, input logic am, input logic dm, input logic tk, input logic md);
    bitValid = bv; actMatch = am; deaMatch = dm; msTick = tk; autoMode = md;
    @(negedge clk);
  endtask

  task automatic doReset();
    bitValid = 0; actMatch = 0; deaMatch = 0; msTick = 0; autoMode = 0;
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog: got running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    doReset();
    checkAll("R9 reset", 1'b0, 1'b0, 1'b0);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      logic [19:0] e;
      e = VEC[i];
      for (int k = 0; k < int'(e[19:12]); k++) step(e[11], e[10], e[9], e[8], e[7]);
      checkAll($sformatf("R%0d vector %0d", e[3:0], i), e[6], e[5], e[4]);
    end

    // R9: reset while the down status is held
    doReset();
    checkAll("R9 mid-run reset", 1'b0, 1'b0, 1'b0);
    rstN = 1'b1;

    // R2: long persistence, both codes present, then R8 priority
    for (int k = 0; k < TL - 1; k++) step(1, 1, 1, 1, 1);
    check("R2 no set before long count", actStatus, 1'b0);
    step(1, 1, 1, 1, 1);
    check("R2 up set at long count", actStatus, 1'b1);
    check("R2 down set at long count", deaStatus, 1'b1);
    step(1, 1, 1, 1, 1);
    check("R8 simultaneous rise keeps loopback off", remoteLoopback, 1'b0);

    // R3: restart of qualification on reaching the limit
    doReset();
    rstN = 1'b1;
    for (int k = 0; k < 3; k++) step(1, 1, 1, 1, 0);
    step(1, 0, 1, 1, 0);
    step(1, 0, 1, 0, 0);
    for (int k = 0; k < TS - 1; k++) step(1, 1, 1, 1, 0);
    check("R3 count restarted", actStatus, 1'b0);
    step(1, 1, 1, 1, 0);
    check("R3 sets after full recount", actStatus, 1'b1);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule